// File: doc/BRIEF.md
# Block Cipher Job Sequencer with Control Registers

This block is the software-facing front end of a secure-memory cipher unit. A 32-bit register port lets software set the block indices where the plaintext (red) and ciphertext (black) regions start, a block count, two initialization-vector words and a mode word. It also exposes a read-only configuration word that describes the memory geometry. Setting the start bit in the mode word launches a job. The sequencer then issues one request per block to an external cipher engine and waits for that block's completion pulse before it moves on. When the last block is acknowledged, the block raises latched completion and interrupt flags.

A memory zeroize command runs a fixed-length busy period with no engine traffic and sets the same interrupt flag when it ends. Software polls the busy flag until it falls, writes the interrupt-clear command and then reads its results. The mode register cannot be changed while a job or a zeroize is running. A start request whose block count exceeds the configured capacity is refused and flagged instead.

The sequencer has four states. S_IDLE goes to S_REQ on an accepted start, and to S_ZERO on an accepted zeroize. S_REQ stays put until the engine pulses done. On done it goes to S_GAP, or to S_IDLE if that was the final block. S_GAP always returns to S_REQ with the next block index. S_ZERO counts ZERO_CYCLES cycles and then returns to S_IDLE.

Top module: `cipher_seq_regs`

## Requirements
- R1: After reset, every writable register reads 0, the status and error words read 0, `irq` is 0 and `eng_req` is 0.
- R2: Register offsets are 0x00 red base, 0x04 black base, 0x08 length, 0x0C mode, 0x10 status, 0x14 error, 0x18 interrupt control, 0x1C configuration, 0x20 IV low and 0x24 IV high. The base and length registers keep their low 10 bits. The configuration word reads bytes-per-block in bits 6:0, red capacity in blocks in bits 16:7 and black capacity in bits 26:17, and writes to it have no effect.
- R3: Mode bit 0 selects decrypt and bit 1 selects chaining; both read back in the same positions and drive `eng_decrypt` and `eng_chain`. Bit 2 starts a job and reads back as 0.
- R4: Status bit 0 (busy) and bit 2 (ciphering) rise in the cycle after an accepted start write. They stay high until the done pulse of block length+1 is taken, and exactly length+1 engine requests are issued.
- R5: For block k of a job, `eng_src_blk` is the red base plus k when encrypting and the black base plus k when decrypting; `eng_dst_blk` is the other region's base plus k.
- R6: A mode write while busy leaves the mode bits and the job untouched and sets error bit 1.
- R7: A start write with length+1 greater than the smaller of the two capacities starts nothing, sets status bit 12 and sets error bit 0.
- R8: Job completion sets status bit 8 (pending) and bit 10 (done). Both stay set until interrupt control is written with bit 1 set, which clears pending, done and the length-error flag.
- R9: `irq` is high exactly when pending is set and interrupt control bit 0 (mask) is clear.
- R10: Writing any value to the error word clears it to 0.
- R11: Interrupt control bit 2, written while idle, makes status bits 0 (busy) and 1 (zeroizing) high for ZERO_CYCLES cycles with no engine request and ciphering low, and then sets pending. It is ignored while busy.
- R12: `eng_iv` presents {IV high, IV low}. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| eng_req | output | 1 | Block request to the cipher engine |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_decrypt | output | 1 | Direction for the engine |
| eng_chain | output | 1 | Chaining enable for the engine |
| eng_src_blk | output | ADDR_W | Source block index |
| eng_dst_blk | output | ADDR_W | Destination block index |
| eng_iv | output | 64 | Initialization vector |

## Verification
The assertions take several things for granted. The bus carries at most one write per cycle. `eng_done` pulses for a single cycle and only while `eng_req` is high. An interrupt-clear write never coincides with the cycle in which a job or zeroize completes. The bench's engine model acknowledges each request after a fixed delay and then drops `done` at once. The stimulus issues its clear writes only after polling has shown busy low, so no clear falls on a completion edge.

// File: rtl/cipher_seq_pkg.sv
package cipher_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_GAP  = 2'd2,
        S_ZERO = 2'd3
    } cseq_state_e;

    localparam logic [7:0] OFF_RED   = 8'h00;
    localparam logic [7:0] OFF_BLACK = 8'h04;
    localparam logic [7:0] OFF_LEN   = 8'h08;
    localparam logic [7:0] OFF_MODE  = 8'h0C;
    localparam logic [7:0] OFF_STAT  = 8'h10;
    localparam logic [7:0] OFF_ERR   = 8'h14;
    localparam logic [7:0] OFF_ICTL  = 8'h18;
    localparam logic [7:0] OFF_CFG   = 8'h1C;
    localparam logic [7:0] OFF_IV0   = 8'h20;
    localparam logic [7:0] OFF_IV1   = 8'h24;

    localparam int ST_BUSY  = 0;
    localparam int ST_ZERO  = 1;
    localparam int ST_CIPH  = 2;
    localparam int ST_PEND  = 8;
    localparam int ST_DONE  = 10;
    localparam int ST_LENER = 12;

endpackage

// File: rtl/cseq_fsm.sv
module cseq_fsm
    import cipher_seq_pkg::*;
#(
    parameter int LEN_W       = 10,
    parameter int ZERO_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_go,
    input  logic             zero_go,
    input  logic [LEN_W-1:0] len_q,
    input  logic             eng_done,
    output logic             eng_req,
    output logic [LEN_W-1:0] blk_idx,
    output logic             busy,
    output logic             zeroizing,
    output logic             ciphering,
    output logic             job_end,
    output logic             zero_end
);
    localparam int ZC_W = $clog2(ZERO_CYCLES + 1);

    cseq_state_e      state_q, state_n;
    logic [LEN_W-1:0] idx_q, last_q;
    logic [ZC_W-1:0]  zcnt_q;
    logic             at_last;

    assign at_last = (idx_q == last_q);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_go)     state_n = S_REQ;
                else if (zero_go) state_n = S_ZERO;
            end
            S_REQ:  if (eng_done) state_n = at_last ? S_IDLE : S_GAP;
            S_GAP:  state_n = S_REQ;
            S_ZERO: if (zcnt_q == '0) state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
            zcnt_q  <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == S_IDLE && start_go) begin
                idx_q  <= '0;
                last_q <= len_q;
            end else if (state_q == S_REQ && eng_done && !at_last) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == S_IDLE && zero_go)
                zcnt_q <= ZC_W'(ZERO_CYCLES - 1);
            else if (state_q == S_ZERO && zcnt_q != '0)
                zcnt_q <= zcnt_q - 1'b1;
        end
    end

    always_comb begin
        eng_req   = (state_q == S_REQ);
        busy      = (state_q != S_IDLE);
        zeroizing = (state_q == S_ZERO);
        ciphering = (state_q == S_REQ) || (state_q == S_GAP);
        job_end   = (state_q == S_REQ) && eng_done && at_last;
        zero_end  = (state_q == S_ZERO) && (zcnt_q == '0);
        blk_idx   = idx_q;
    end

endmodule

// File: rtl/cseq_regs.sv
module cseq_regs
    import cipher_seq_pkg::*;
#(
    parameter int          ADDR_W   = 10,
    parameter int          LEN_W    = 10,
    parameter int          CAP      = 48,
    parameter logic [31:0] CFG_WORD = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              zeroizing,
    input  logic              ciphering,
    input  logic              job_end,
    input  logic              zero_end,
    output logic              start_go,
    output logic              zero_go,
    output logic [LEN_W-1:0]  len_q,
    output logic [ADDR_W-1:0] red_q,
    output logic [ADDR_W-1:0] black_q,
    output logic              decrypt_q,
    output logic              chain_q,
    output logic [63:0]       iv_q,
    output logic              pend_q,
    output logic              mask_q
);
    logic       done_q, lenerr_q;
    logic [1:0] err_q;
    logic       wr_mode, wr_ictl, wr_err, len_fits, len_bad, busy_hit, clr;
    logic [31:0] stat_w;

    assign wr_mode  = wr && (addr == OFF_MODE);
    assign wr_ictl  = wr && (addr == OFF_ICTL);
    assign wr_err   = wr && (addr == OFF_ERR);
    assign len_fits = (int'(len_q) + 1) <= CAP;
    assign start_go = wr_mode && !busy && wdata[2] && len_fits;
    assign len_bad  = wr_mode && !busy && wdata[2] && !len_fits;
    assign busy_hit = wr_mode && busy;
    assign zero_go  = wr_ictl && !busy && wdata[2];
    assign clr      = wr_ictl && wdata[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_q     <= '0;
            black_q   <= '0;
            len_q     <= '0;
            decrypt_q <= 1'b0;
            chain_q   <= 1'b0;
            iv_q      <= '0;
            mask_q    <= 1'b0;
            pend_q    <= 1'b0;
            done_q    <= 1'b0;
            lenerr_q  <= 1'b0;
            err_q     <= '0;
        end else begin
            if (wr && addr == OFF_RED)   red_q   <= wdata[ADDR_W-1:0];
            if (wr && addr == OFF_BLACK) black_q <= wdata[ADDR_W-1:0];
            if (wr && addr == OFF_LEN)   len_q   <= wdata[LEN_W-1:0];
            if (wr && addr == OFF_IV0)   iv_q[31:0]  <= wdata;
            if (wr && addr == OFF_IV1)   iv_q[63:32] <= wdata;
            if (wr_mode && !busy) begin
                decrypt_q <= wdata[0];
                chain_q   <= wdata[1];
            end
            if (wr_ictl) mask_q <= wdata[0];
            pend_q   <= (job_end || zero_end) ? 1'b1 : (clr ? 1'b0 : pend_q);
            done_q   <= job_end ? 1'b1 : (clr ? 1'b0 : done_q);
            lenerr_q <= len_bad ? 1'b1 : (clr ? 1'b0 : lenerr_q);
            if (wr_err) err_q <= '0;
            else        err_q <= err_q | {busy_hit, len_bad};
        end
    end

    always_comb begin
        stat_w           = '0;
        stat_w[ST_BUSY]  = busy;
        stat_w[ST_ZERO]  = zeroizing;
        stat_w[ST_CIPH]  = ciphering;
        stat_w[ST_PEND]  = pend_q;
        stat_w[ST_DONE]  = done_q;
        stat_w[ST_LENER] = lenerr_q;
        case (addr)
            OFF_RED:   rdata = 32'(red_q);
            OFF_BLACK: rdata = 32'(black_q);
            OFF_LEN:   rdata = 32'(len_q);
            OFF_MODE:  rdata = {30'd0, chain_q, decrypt_q};
            OFF_STAT:  rdata = stat_w;
            OFF_ERR:   rdata = {30'd0, err_q};
            OFF_ICTL:  rdata = {31'd0, mask_q};
            OFF_CFG:   rdata = CFG_WORD;
            OFF_IV0:   rdata = iv_q[31:0];
            OFF_IV1:   rdata = iv_q[63:32];
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/cipher_seq_regs.sv
module cipher_seq_regs #(
    parameter int ADDR_W       = 10,
    parameter int LEN_W        = 10,
    parameter int BLOCK_BYTES  = 8,
    parameter int RED_BLOCKS   = 64,
    parameter int BLACK_BLOCKS = 48,
    parameter int ZERO_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              eng_req,
    input  logic              eng_done,
    output logic              eng_decrypt,
    output logic              eng_chain,
    output logic [ADDR_W-1:0] eng_src_blk,
    output logic [ADDR_W-1:0] eng_dst_blk,
    output logic [63:0]       eng_iv
);
    localparam int CAP = (RED_BLOCKS < BLACK_BLOCKS) ? RED_BLOCKS : BLACK_BLOCKS;
    localparam logic [31:0] CFG_WORD = (32'(BLOCK_BYTES) & 32'h7F)
                                     | ((32'(RED_BLOCKS) & 32'h3FF) << 7)
                                     | ((32'(BLACK_BLOCKS) & 32'h3FF) << 17);

    logic              start_go, zero_go, busy, zeroizing, ciphering, job_end, zero_end;
    logic              pend_q, mask_q;
    logic [LEN_W-1:0]  len_q, blk_idx;
    logic [ADDR_W-1:0] red_q, black_q, red_cur, black_cur;

    cseq_regs #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CAP(CAP), .CFG_WORD(CFG_WORD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .zeroizing(zeroizing), .ciphering(ciphering),
        .job_end(job_end), .zero_end(zero_end), .start_go(start_go), .zero_go(zero_go),
        .len_q(len_q), .red_q(red_q), .black_q(black_q), .decrypt_q(eng_decrypt),
        .chain_q(eng_chain), .iv_q(eng_iv), .pend_q(pend_q), .mask_q(mask_q)
    );

    cseq_fsm #(
        .LEN_W(LEN_W), .ZERO_CYCLES(ZERO_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_go(start_go), .zero_go(zero_go),
        .len_q(len_q), .eng_done(eng_done), .eng_req(eng_req), .blk_idx(blk_idx),
        .busy(busy), .zeroizing(zeroizing), .ciphering(ciphering),
        .job_end(job_end), .zero_end(zero_end)
    );

    assign red_cur     = red_q + ADDR_W'(blk_idx);
    assign black_cur   = black_q + ADDR_W'(blk_idx);
    assign eng_src_blk = eng_decrypt ? black_cur : red_cur;
    assign eng_dst_blk = eng_decrypt ? red_cur : black_cur;
    assign irq         = pend_q && !mask_q;

endmodule

// File: rtl/cseq_checker.sv
module cseq_checker #(
    parameter int LEN_W = 10,
    parameter int CAP   = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_start_wr,
    input logic             clear_wr,
    input logic             busy,
    input logic             zeroizing,
    input logic             eng_req,
    input logic             eng_decrypt,
    input logic             pend_q,
    input logic [LEN_W-1:0] len_q
);
    a_r4_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> busy);

    a_r4_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_start_wr && !busy && (int'(len_q) + 1 <= CAP)) |=> (busy && !zeroizing));

    a_r7_oversize_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_start_wr && !busy && (int'(len_q) + 1 > CAP)) |=> !busy);

    a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(eng_decrypt));

    a_r8_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clear_wr) |=> pend_q);

    a_r11_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        zeroizing |-> !eng_req);
endmodule

bind cipher_seq_regs cseq_checker #(.LEN_W(LEN_W), .CAP(CAP)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .mode_start_wr(reg_wr && reg_addr == 8'h0C && reg_wdata[2]),
    .clear_wr(reg_wr && reg_addr == 8'h18 && reg_wdata[1]),
    .busy(busy),
    .zeroizing(zeroizing),
    .eng_req(eng_req),
    .eng_decrypt(eng_decrypt),
    .pend_q(pend_q),
    .len_q(len_q)
);

// File: tb/sim_cipher_seq_regs.sv
module sim_cipher_seq_regs;
    localparam int CLK_PERIOD = 10;
    localparam int CAP   = 48;
    localparam int ZC    = 4;
    localparam int DLY   = 2;
    localparam logic [31:0] CFG = 32'd8 | (32'd64 << 7) | (32'd48 << 17);

    logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, eng_done = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, eng_req, eng_decrypt, eng_chain;
    logic [9:0]  eng_src_blk, eng_dst_blk;
    logic [63:0] eng_iv;

    int checks = 0, errors = 0;
    int m_ph = 0, m_blk = 0, m_nblk = 0, m_zl = 0, dcnt = 0, nreq = 0;
    logic [31:0] m_red = 0, m_black = 0, m_len = 0, m_iv0 = 0, m_iv1 = 0, m_err = 0;
    logic m_dec = 0, m_chn = 0, m_mask = 0, m_pend = 0, m_done = 0, m_lerr = 0;
    logic wb, set_p, set_d;

    cipher_seq_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .eng_req(eng_req),
        .eng_done(eng_done), .eng_decrypt(eng_decrypt), .eng_chain(eng_chain),
        .eng_src_blk(eng_src_blk), .eng_dst_blk(eng_dst_blk), .eng_iv(eng_iv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_blk = 0; m_nblk = 0; m_zl = 0;
            m_red = 0; m_black = 0; m_len = 0; m_iv0 = 0; m_iv1 = 0; m_err = 0;
            m_dec = 0; m_chn = 0; m_mask = 0; m_pend = 0; m_done = 0; m_lerr = 0;
        end else begin
            wb = (m_ph != 0); set_p = 0; set_d = 0;
            case (m_ph)
                1: if (eng_done) begin
                       if (m_blk + 1 == m_nblk) begin m_ph = 0; set_p = 1; set_d = 1; end
                       else begin m_ph = 2; m_blk++; end
                   end
                2: m_ph = 1;
                3: begin m_zl--; if (m_zl == 0) begin m_ph = 0; set_p = 1; end end
                default: ;
            endcase
            if (reg_wr) case (reg_addr)
                8'h00: m_red   = reg_wdata & 32'h3FF;
                8'h04: m_black = reg_wdata & 32'h3FF;
                8'h08: m_len   = reg_wdata & 32'h3FF;
                8'h20: m_iv0   = reg_wdata;
                8'h24: m_iv1   = reg_wdata;
                8'h14: m_err   = 0;
                8'h0C: if (wb) m_err = m_err | 2;
                       else begin
                           m_dec = reg_wdata[0]; m_chn = reg_wdata[1];
                           if (reg_wdata[2]) begin
                               if (int'(m_len) + 1 > CAP) begin m_lerr = 1; m_err = m_err | 1; end
                               else begin m_ph = 1; m_blk = 0; m_nblk = int'(m_len) + 1; end
                           end
                       end
                8'h18: begin
                    m_mask = reg_wdata[0];
                    if (reg_wdata[1]) begin m_pend = 0; m_done = 0; m_lerr = 0; end
                    if (reg_wdata[2] && !wb) begin m_ph = 3; m_zl = ZC; end
                end
                default: ;
            endcase
            if (set_p) m_pend = 1;
            if (set_d) m_done = 1;
        end
    end

    // per-cycle comparison, then the delayed-acknowledge engine
    always @(negedge clk) begin
        if (rst_n) begin
            chk(64'(irq), 64'(m_pend && !m_mask), "R9 irq");
            chk(64'(eng_req), 64'(m_ph == 1), "R4 eng_req");
            chk(64'(eng_decrypt), 64'(m_dec), "R3 eng_decrypt");
            chk(64'(eng_chain), 64'(m_chn), "R3 eng_chain");
            chk(eng_iv, {m_iv1, m_iv0}, "R12 eng_iv");
            if (m_ph == 1) begin
                chk(64'(eng_src_blk), 64'(10'((m_dec ? m_black : m_red) + m_blk)), "R5 src");
                chk(64'(eng_dst_blk), 64'(10'((m_dec ? m_red : m_black) + m_blk)), "R5 dst");
            end
        end
        if (!rst_n) begin dcnt = 0; eng_done = 0; end
        else if (dcnt > 0) begin dcnt--; eng_done = (dcnt == 0); end
        else begin
            eng_done = 0;
            if (eng_req) begin dcnt = DLY; nreq++; end
        end
    end

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[0] = (m_ph != 0); s[1] = (m_ph == 3); s[2] = (m_ph == 1 || m_ph == 2);
        s[8] = m_pend; s[10] = m_done; s[12] = m_lerr;
        return s;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_addr = 8'h10;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); reg_addr = a; #1;
        chk(64'(reg_rdata), 64'(exp), req);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk); reg_addr = 8'h10; #1;
            if (reg_rdata[0] == 1'b0) return;
        end
        chk(1, 0, "R4 busy never fell");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(8'h00, 0, "R1 red"); rd(8'h08, 0, "R1 len"); rd(8'h0C, 0, "R1 mode");
        rd(8'h10, 0, "R1 status"); rd(8'h14, 0, "R1 error"); rd(8'h18, 0, "R1 ictl");
        chk(64'(irq), 0, "R1 irq"); chk(64'(eng_req), 0, "R1 eng_req");
        // R2 register map and read-only configuration
        wr(8'h00, 32'hFFFF_F020); wr(8'h04, 32'h100); wr(8'h08, 2);
        wr(8'h20, 32'hDEAD_BEEF); wr(8'h24, 32'h0123_4567);
        rd(8'h00, 32'h020, "R2 red low bits"); rd(8'h04, 32'h100, "R2 black");
        rd(8'h08, 2, "R2 len"); rd(8'h1C, CFG, "R2 cfg");
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, CFG, "R2 cfg write ignored");
        rd(8'h24, 32'h0123_4567, "R12 iv high"); rd(8'h30, 0, "R12 unmapped");
        rd(8'h02, 0, "R12 misaligned");
        // R3/R4/R5 encrypt, chained, three blocks; R6 mode write while busy
        nreq = 0;
        wr(8'h0C, 32'h6);
        rd(8'h10, exp_status(), "R4 busy and ciphering");
        wr(8'h0C, 32'h1);
        rd(8'h0C, 32'h2, "R6 mode unchanged while busy");
        wait_idle();
        chk(64'(nreq), 3, "R4 request count");
        rd(8'h10, 32'h0000_0500, "R8 pending and done");
        rd(8'h14, 2, "R6 error bit 1");
        // R9 masking
        wr(8'h18, 1); chk(64'(irq), 0, "R9 masked");
        wr(8'h18, 0); chk(64'(irq), 1, "R9 unmasked");
        // R8 clear
        wr(8'h18, 2); rd(8'h10, 0, "R8 cleared");
        // R10 error clear
        wr(8'h14, 32'h1234); rd(8'h14, 0, "R10 error cleared");
        // R5 decrypt, single block
        nreq = 0;
        wr(8'h08, 0); wr(8'h0C, 32'h5); wait_idle();
        chk(64'(nreq), 1, "R4 one block");
        wr(8'h18, 2);
        // R7 oversize and exact capacity
        wr(8'h08, CAP); wr(8'h0C, 32'h4);
        rd(8'h10, 32'h1000, "R7 length error flagged");
        rd(8'h14, 1, "R7 error bit 0");
        wr(8'h18, 2); wr(8'h14, 0);
        nreq = 0;
        wr(8'h08, CAP - 1); wr(8'h0C, 32'h4); wait_idle();
        chk(64'(nreq), CAP, "R7 full capacity runs");
        wr(8'h18, 2);
        // R11 zeroize
        nreq = 0;
        wr(8'h18, 4);
        rd(8'h10, exp_status(), "R11 zeroizing");
        wait_idle();
        chk(64'(nreq), 0, "R11 no engine traffic");
        rd(8'h10, 32'h100, "R11 pending after zeroize");
        wr(8'h18, 2);
        // R11 zeroize while busy is ignored
        wr(8'h08, 3); wr(8'h0C, 32'h4); wr(8'h18, 4);
        rd(8'h10, exp_status(), "R11 ignored while busy");
        wait_idle();
        repeat (6) @(negedge clk);
        rd(8'h10, 32'h500, "R11 no zeroize after job");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule